// File: doc/BRIEF.md
# SD Card Data Path with Word FIFO and Byte Packing

This block is the data path between a processor-side register port and a byte-wide card data port. A circular FIFO of 32-bit words buffers the transfer. During a card read, incoming bytes are packed little-endian into words and pushed into the FIFO, where software pops them through the data register. During a card write, software pushes words and the block sends their bytes to the card, least significant byte first.

A remaining-byte counter controls the transfer. It is loaded with block count times block size when the block-count register is written. At most one byte moves per clock. When the counter reaches zero the block sets the data flag in the status register and raises the interrupt sources that the configuration and the command type select. A debug register shows a state field and the live FIFO word count. Command decode, serial line timing and CRC are handled elsewhere. The command type arrives on three plain inputs.

Top module: `sdx_datapath`

## Requirements
- R1: The FIFO holds DEPTH (16) words and is circular. A push while it is full is dropped, and the stored words and the level do not change.
- R2: A data-register read while the FIFO is empty returns 0 and leaves the level unchanged.
- R3: Register map on `reg_addr`: 0 data, 1 config, 2 block count, 3 block size, 4 status, 5 debug. Writing the block count loads the counter with block count × block size. Loading zero completes the transfer on the next cycle.
- R4: In read mode (`cmd_read`=1) a byte is taken (`card_rx_take`) only when `card_ready` is high, bytes remain, the FIFO is not full, and no data-register access or block-count load happens that cycle. At most one byte moves per clock.
- R5: Byte k of a word goes to bits 8k+7:8k. A word is pushed after its fourth byte, or after the final byte of the transfer with the unused upper lanes zero.
- R6: In write mode a word is popped and its bytes leave on `card_tx_byte` with `card_tx_valid` high, bit 7:0 first, one per clock while bytes remain. Bytes of the last word beyond the count are discarded, and a new load starts on a fresh word.
- R7: On completion, status bit 0 is set and debug bits 3:0 become 1. Status bit 8 is also set if config bit 4 is set. Status bit 10 is set if `cmd_busy` and config bit 10 are set. Status bit 9 is set if `cmd_write` and config bit 8 are set.
- R8: With the counter at zero, any data-register access, config write or block-count write completes again on the next cycle.
- R9: `irq` is high exactly when status bit 8, 9 or 10 is set. A status write clears each bit written as 1. A set in the same cycle wins.
- R10: Debug bits 8:4 always read the current FIFO word count.
- R11: The debug register resets to 0x0000C60F. A write whose bits 3:0 are 0xF stores 0 in those bits.
- R12: Register read data appears on `reg_rdata` the cycle after `reg_rd`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| cmd_read | input | 1 | Current command moves data from the card |
| cmd_write | input | 1 | Current command is a write (block interrupt source) |
| cmd_busy | input | 1 | Current command waits on busy (busy interrupt source) |
| card_ready | input | 1 | Card has a byte available |
| card_rx_byte | input | 8 | Byte from the card |
| card_rx_take | output | 1 | Byte on card_rx_byte is consumed at this edge |
| card_tx_byte | output | 8 | Byte to the card |
| card_tx_valid | output | 1 | card_tx_byte is sent at this edge |
| irq | output | 1 | Interrupt request |

## Verification
Register read data is due one edge after the read strobe. The bench therefore drives strobes on the falling edge and samples `reg_rdata` on the next falling edge. The first card byte moves at the second rising edge after the block-count write. Bytes then move every clock, except in cycles where the data register is accessed. The status, irq and debug state update on the edge of the last byte. The bench waits a fixed margin larger than the byte count before it reads them back. Transmitted bytes are compared just after each falling edge, because `card_tx_valid` at that point marks a byte that leaves at the next rising edge.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int ST_W = 11;

  typedef enum logic [2:0] {
    RA_DATA  = 3'd0,
    RA_CFG   = 3'd1,
    RA_BLKS  = 3'd2,
    RA_BSIZE = 3'd3,
    RA_STAT  = 3'd4,
    RA_DBG   = 3'd5
  } reg_addr_e;

  localparam logic [31:0] DBG_RESET     = 32'h0000_C60F;
  localparam logic [3:0]  DBG_MODE_DATA = 4'h1;

  // place byte b into lane 'lane' of a partially packed word
  function automatic logic [31:0] lane_insert(input logic [31:0] acc,
                                              input logic [7:0]  b,
                                              input logic [1:0]  lane);
    return acc | ({24'h0, b} << {lane, 3'b000});
  endfunction

  // state nibble as stored after a software write
  function automatic logic [3:0] dbg_nib_store(input logic [3:0] wr_nib);
    return (wr_nib == 4'hF) ? 4'h0 : wr_nib;
  endfunction
endpackage

// File: rtl/sdx_word_fifo.sv
module sdx_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (level_q == LVL_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = empty ? '0 : mem[rd_ptr];
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/sdx_byte_engine.sv
module sdx_byte_engine #(
  parameter int BLK_W = 16,
  parameter int BSZ_W = 16,
  parameter int CNT_W = BLK_W + BSZ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] blk_cnt,
  input  logic [BSZ_W-1:0] blk_size,
  input  logic             dir_read,
  input  logic             hold,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [31:0]      fifo_head,
  input  logic             card_ready,
  input  logic [7:0]       rx_byte,
  output logic             rx_take,
  output logic             tx_valid,
  output logic [7:0]       tx_byte,
  output logic             push_req,
  output logic [31:0]      push_word,
  output logic             pop_req,
  output logic             last_byte,
  output logic             cnt_zero,
  output logic [CNT_W-1:0] remaining
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       lane_q;
  logic [31:0]      acc_q;
  logic [1:0]       tx_left_q;
  logic [23:0]      shreg_q;
  logic             final_in;
  logic [31:0]      packed_w;
  logic [CNT_W-1:0] load_val;

  assign load_val  = CNT_W'(blk_cnt) * CNT_W'(blk_size);
  assign remaining = cnt_q;

  always_comb begin
    cnt_zero  = (cnt_q == '0);
    final_in  = (cnt_q == CNT_W'(1));
    packed_w  = sdx_pkg::lane_insert(acc_q, rx_byte, lane_q);
    rx_take   = dir_read & card_ready & ~cnt_zero & ~fifo_full & ~hold & ~load;
    push_req  = rx_take & ((lane_q == 2'd3) | final_in);
    push_word = packed_w;
    tx_valid  = ~dir_read & ~cnt_zero & ((tx_left_q != 2'd0) | ~fifo_empty)
                & ~hold & ~load;
    pop_req   = tx_valid & (tx_left_q == 2'd0);
    tx_byte   = (tx_left_q == 2'd0) ? fifo_head[7:0] : shreg_q[7:0];
    last_byte = (rx_take | tx_valid) & final_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lane_q    <= '0;
      acc_q     <= '0;
      tx_left_q <= '0;
      shreg_q   <= '0;
    end else if (load) begin
      cnt_q     <= load_val;
      lane_q    <= '0;
      acc_q     <= '0;
      tx_left_q <= '0;
      shreg_q   <= '0;
    end else begin
      if (rx_take | tx_valid) cnt_q <= cnt_q - CNT_W'(1);
      if (rx_take) begin
        if (push_req) begin
          acc_q  <= '0;
          lane_q <= '0;
        end else begin
          acc_q  <= packed_w;
          lane_q <= lane_q + 2'd1;
        end
      end
      if (tx_valid) begin
        if (tx_left_q == 2'd0) begin
          shreg_q   <= fifo_head[31:8];
          tx_left_q <= 2'd3;
        end else begin
          shreg_q   <= {8'h00, shreg_q[23:8]};
          tx_left_q <= tx_left_q - 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/sdx_status_unit.sv
module sdx_status_unit (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     done_evt,
  input  logic                     en_data_irq,
  input  logic                     en_block_irq,
  input  logic                     en_busy_irq,
  input  logic                     cmd_write,
  input  logic                     cmd_busy,
  input  logic                     clr_en,
  input  logic [sdx_pkg::ST_W-1:0] clr_mask,
  input  logic                     dbg_wr,
  input  logic [31:0]              dbg_wdata,
  input  logic [4:0]               fifo_level5,
  output logic [sdx_pkg::ST_W-1:0] status,
  output logic [31:0]              dbg_view,
  output logic [3:0]               dbg_state,
  output logic                     irq
);
  import sdx_pkg::*;

  logic [ST_W-1:0] status_q, set_mask, clr_bits;
  logic [31:9]     dbg_hi_q;
  logic [3:0]      dbg_nib_q;

  always_comb begin
    set_mask = '0;
    if (done_evt) begin
      set_mask[0]  = 1'b1;
      set_mask[8]  = en_data_irq;
      set_mask[9]  = cmd_write & en_block_irq;
      set_mask[10] = cmd_busy & en_busy_irq;
    end
    clr_bits = clr_en ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      dbg_hi_q  <= DBG_RESET[31:9];
      dbg_nib_q <= DBG_RESET[3:0];
    end else begin
      status_q <= (status_q & ~clr_bits) | set_mask;
      if (dbg_wr) begin
        dbg_hi_q  <= dbg_wdata[31:9];
        dbg_nib_q <= dbg_nib_store(dbg_wdata[3:0]);
      end
      if (done_evt) dbg_nib_q <= DBG_MODE_DATA;
    end
  end

  assign status    = status_q;
  assign dbg_view  = {dbg_hi_q, fifo_level5, dbg_nib_q};
  assign dbg_state = dbg_nib_q;
  assign irq       = |status_q[10:8];
endmodule

// File: rtl/sdx_datapath.sv
module sdx_datapath #(
  parameter int DEPTH = 16,
  parameter int BLK_W = 16,
  parameter int BSZ_W = 16,
  parameter int CFG_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cmd_read,
  input  logic        cmd_write,
  input  logic        cmd_busy,
  input  logic        card_ready,
  input  logic [7:0]  card_rx_byte,
  output logic        card_rx_take,
  output logic [7:0]  card_tx_byte,
  output logic        card_tx_valid,
  output logic        irq
);
  import sdx_pkg::*;

  localparam int CNT_W = BLK_W + BSZ_W;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [CFG_W-1:0] cfg_q;
  logic [BLK_W-1:0] blk_q;
  logic [BSZ_W-1:0] bsz_q;
  logic             run_q;

  logic             data_wr, data_rd, hold, load_cnt, run_req;
  logic             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [31:0]      fifo_wdata, fifo_head;
  logic [LVL_W-1:0] fifo_level;
  logic             eng_push, eng_pop, last_byte, cnt_zero, done_evt;
  logic [31:0]      eng_word;
  logic [CNT_W-1:0] xfer_cnt;
  logic [ST_W-1:0]  status_q;
  logic [31:0]      dbg_view;
  logic [3:0]       dbg_state;
  logic [31:0]      rd_mux;

  assign data_wr  = reg_wr & (reg_addr == RA_DATA);
  assign data_rd  = reg_rd & (reg_addr == RA_DATA);
  assign hold     = data_wr | data_rd;
  assign load_cnt = reg_wr & (reg_addr == RA_BLKS);
  assign run_req  = data_wr | data_rd | load_cnt | (reg_wr & (reg_addr == RA_CFG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      blk_q <= '0;
      bsz_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_req;
      if (reg_wr && reg_addr == RA_CFG)   cfg_q <= reg_wdata[CFG_W-1:0];
      if (load_cnt)                       blk_q <= reg_wdata[BLK_W-1:0];
      if (reg_wr && reg_addr == RA_BSIZE) bsz_q <= reg_wdata[BSZ_W-1:0];
    end
  end

  assign fifo_push  = data_wr | eng_push;
  assign fifo_wdata = data_wr ? reg_wdata : eng_word;
  assign fifo_pop   = data_rd | eng_pop;
  assign done_evt   = last_byte | (run_q & cnt_zero);

  sdx_word_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .head(fifo_head), .level(fifo_level),
    .full(fifo_full), .empty(fifo_empty)
  );

  sdx_byte_engine #(.BLK_W(BLK_W), .BSZ_W(BSZ_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .load(load_cnt),
    .blk_cnt(reg_wdata[BLK_W-1:0]), .blk_size(bsz_q),
    .dir_read(cmd_read), .hold(hold),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
    .card_ready(card_ready), .rx_byte(card_rx_byte),
    .rx_take(card_rx_take), .tx_valid(card_tx_valid), .tx_byte(card_tx_byte),
    .push_req(eng_push), .push_word(eng_word), .pop_req(eng_pop),
    .last_byte(last_byte), .cnt_zero(cnt_zero), .remaining(xfer_cnt)
  );

  sdx_status_unit u_status (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt),
    .en_data_irq(cfg_q[4]), .en_block_irq(cfg_q[8]), .en_busy_irq(cfg_q[10]),
    .cmd_write(cmd_write), .cmd_busy(cmd_busy),
    .clr_en(reg_wr && reg_addr == RA_STAT), .clr_mask(reg_wdata[ST_W-1:0]),
    .dbg_wr(reg_wr && reg_addr == RA_DBG), .dbg_wdata(reg_wdata),
    .fifo_level5(5'(fifo_level)),
    .status(status_q), .dbg_view(dbg_view), .dbg_state(dbg_state), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      RA_DATA:  rd_mux = fifo_head;
      RA_CFG:   rd_mux = 32'(cfg_q);
      RA_BLKS:  rd_mux = 32'(blk_q);
      RA_BSIZE: rd_mux = 32'(bsz_q);
      RA_STAT:  rd_mux = 32'(status_q);
      RA_DBG:   rd_mux = dbg_view;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/sdx_datapath_chk.sv
module sdx_datapath_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             cmd_read,
  input logic             card_ready,
  input logic             card_rx_take,
  input logic             card_tx_valid,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [LVL_W-1:0] fifo_level,
  input logic             load_cnt,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic             done_evt,
  input logic [10:0]      status_q,
  input logic [3:0]       dbg_state
);
  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R1
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && fifo_push && !fifo_pop) |=> $stable(fifo_level));

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && fifo_pop && !fifo_push) |=> $stable(fifo_level));

  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rx_take |-> (card_ready && cmd_read && !card_tx_valid));

  // R6
  tx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_tx_valid |-> !cmd_read);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((card_rx_take || card_tx_valid) && !load_cnt) |=>
      (xfer_cnt == $past(xfer_cnt) - CNT_W'(1)));

  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (status_q[0] && dbg_state == 4'h1));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && reg_wdata[8] && !done_evt) |=> !status_q[8]);
endmodule

bind sdx_datapath sdx_datapath_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_read(cmd_read), .card_ready(card_ready),
  .card_rx_take(card_rx_take), .card_tx_valid(card_tx_valid),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .fifo_level(fifo_level), .load_cnt(load_cnt),
  .xfer_cnt(xfer_cnt), .done_evt(done_evt), .status_q(status_q),
  .dbg_state(dbg_state)
);

// File: tb/sdx_datapath_test.sv
`timescale 1ns/1ps
module sdx_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_read = 1'b0, cmd_write = 1'b0, cmd_busy = 1'b0;
  logic        card_ready = 1'b0;
  logic [7:0]  card_rx_byte;
  logic        card_rx_take, card_tx_valid, irq;
  logic [7:0]  card_tx_byte;

  int total = 0, bad = 0, cyc = 0, rx_idx = 0, tx_count = 0;
  logic [31:0] exp_words[$];
  logic [7:0]  exp_bytes[$];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  sdx_datapath uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_busy(cmd_busy),
    .card_ready(card_ready), .card_rx_byte(card_rx_byte),
    .card_rx_take(card_rx_take), .card_tx_byte(card_tx_byte),
    .card_tx_valid(card_tx_valid), .irq(irq)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) & 255);
  endfunction

  assign card_rx_byte = pat(rx_idx);
  always @(posedge clk) if (rst_n && card_rx_take) rx_idx <= rx_idx + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected packed words of a card read
  task automatic sb_expect_rx(input int start, input int nbytes);
    logic [31:0] w = '0;
    for (int k = 0; k < nbytes; k++) begin
      w = w | (32'(pat(start + k)) << (8 * (k % 4)));
      if ((k % 4) == 3 || k == nbytes - 1) begin
        exp_words.push_back(w);
        w = '0;
      end
    end
  endtask

  task automatic sb_expect_tx(input logic [31:0] w, input int nb);
    for (int k = 0; k < nb; k++) exp_bytes.push_back(w[8*k +: 8]);
  endtask

  // monitor side for words: pop the data register and compare
  task automatic sb_pop_word(input string tag);
    logic [31:0] got;
    rd(3'd0, got);
    if (exp_words.size() == 0) chk({tag, " extra word"}, got, 32'hx);
    else chk(tag, got, exp_words.pop_front());
  endtask

  // monitor for bytes sent to the card (R6)
  always @(negedge clk) begin
    #1;
    if (rst_n && card_tx_valid) begin
      tx_count++;
      if (exp_bytes.size() == 0) chk("R6 unexpected tx byte", 32'(card_tx_byte), 32'hx);
      else chk("R6 tx byte order", 32'(card_tx_byte), 32'(exp_bytes.pop_front()));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // reset state
    rd(3'd4, v); chk("R9 status after reset", v, 32'h0);
    chk("R9 irq after reset", 32'(irq), 32'h0);
    rd(3'd5, v); chk("R11 debug reset value", v, 32'h0000C60F);
    rd(3'd0, v); chk("R2 empty pop returns zero", v, 32'h0);
    rd(3'd5, v); chk("R8 r2_ completion after pop, level 0", v, 32'h0000C601);
    rd(3'd4, v); chk("R8 data flag from run at zero count", v, 32'h1);

    // read transfer of 6 bytes: one full and one partial word
    cmd_read = 1'b1; card_ready = 1'b1;
    wr(3'd1, 32'h010);
    wr(3'd4, 32'h7FF);
    rd(3'd4, v); chk("R9 status cleared", v, 32'h0);
    chk("R9 irq low after clear", 32'(irq), 32'h0);
    wr(3'd3, 32'd6);
    sb_expect_rx(rx_idx, 6);
    wr(3'd2, 32'd1);
    idle(10);
    chk("R4 six bytes taken", 32'(rx_idx), 32'd6);
    rd(3'd5, v); chk("R10 level 2 and data-mode state", v, 32'h0000C621);
    rd(3'd4, v); chk("R7 data flag and data irq", v, 32'h101);
    chk("R9 irq high", 32'(irq), 32'h1);
    sb_pop_word("R5 full word little-endian");
    sb_pop_word("R5 partial final word");
    rd(3'd0, v); chk("R2 pop after drain", v, 32'h0);

    // selective clear
    wr(3'd4, 32'h100);
    rd(3'd4, v); chk("R9 only written bits cleared", v, 32'h001);
    chk("R9 irq low with bit8 clear", 32'(irq), 32'h0);

    // card not ready, then FIFO-full stall
    card_ready = 1'b0;
    wr(3'd4, 32'h7FF);
    wr(3'd3, 32'd80);
    sb_expect_rx(rx_idx, 80);
    wr(3'd2, 32'd1);
    idle(6);
    chk("R4 no take while card not ready", 32'(rx_idx), 32'd6);
    card_ready = 1'b1;
    idle(100);
    chk("R4 r1_ stall at full FIFO", 32'(rx_idx), 32'd70);
    rd(3'd5, v); chk("R10 level 16 shown", v, 32'h0000C701);
    rd(3'd4, v); chk("R7 no completion mid transfer", v, 32'h0);
    for (int i = 0; i < 20; i++) begin
      sb_pop_word("R5 r4_ long read word");
      idle(3);
    end
    chk("R4 all 80 bytes taken", 32'(rx_idx), 32'd86);
    rd(3'd4, v); chk("R7 completion after long read", v, 32'h101);

    // write transfer: 7 bytes from two words
    cmd_read = 1'b0; cmd_write = 1'b1; cmd_busy = 1'b1;
    wr(3'd1, 32'h500);
    wr(3'd3, 32'd7);
    wr(3'd2, 32'd1);
    wr(3'd4, 32'h7FF);
    sb_expect_tx(32'h44332211, 4);
    sb_expect_tx(32'h88776655, 3);
    wr(3'd0, 32'h44332211);
    wr(3'd0, 32'h88776655);
    idle(20);
    chk("R6 seven bytes sent", 32'(tx_count), 32'd7);
    rd(3'd4, v); chk("R7 block and busy sources", v, 32'h601);
    chk("R9 irq from block/busy", 32'(irq), 32'h1);
    rd(3'd5, v); chk("R10 level 0 after write", v, 32'h0000C601);
    wr(3'd3, 32'd1);
    sb_expect_tx(32'h000000AA, 1);
    wr(3'd2, 32'd1);
    wr(3'd0, 32'h000000AA);
    idle(8);
    chk("R6 leftover byte discarded", 32'(tx_count), 32'd8);
    chk("R6 scoreboard drained", 32'(exp_bytes.size()), 32'd0);

    // overflow: 18 pushes into a 16-word FIFO with no card traffic
    cmd_read = 1'b1; cmd_write = 1'b0; cmd_busy = 1'b0; card_ready = 1'b0;
    for (int i = 0; i < 18; i++) begin
      wr(3'd0, 32'hA5000000 | 32'(i));
      if (i < 16) exp_words.push_back(32'hA5000000 | 32'(i));
    end
    rd(3'd5, v); chk("R1 level saturates at 16", v, 32'h0000C701);
    for (int i = 0; i < 16; i++) sb_pop_word("R1 circular order kept");
    rd(3'd0, v); chk("R1 r2_ dropped words absent", v, 32'h0);
    rd(3'd5, v); chk("R2 level stays 0", v, 32'h0000C601);

    // debug register writes
    wr(3'd5, 32'h00ABC123);
    rd(3'd5, v); chk("R11 r10_ debug write view", v, 32'h00ABC003);
    wr(3'd5, 32'h0000500F);
    rd(3'd5, v); chk("R11 all-ones nibble stored as zero", v, 32'h00005000);

    // zero-length load completes
    wr(3'd4, 32'h7FF);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'd5);
    rd(3'd4, v); chk("R3 zero product completes", v, 32'h001);
    rd(3'd5, v); chk("R7 state nibble set to 1", v, 32'h00005001);
    chk("R9 irq low with data flag only", 32'(irq), 32'h0);

    // register map readback
    rd(3'd1, v); chk("R12 config readback", v, 32'h500);
    rd(3'd2, v); chk("R12 r3_ block count readback", v, 32'd5);
    rd(3'd7, v); chk("R12 unmapped reads zero", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule